// File: doc/BRIEF.md
# Button-Triggered Serial Burst Generator

This block holds a 26-bit word and sends it out one bit at a time when a push-button request arrives. The word leaves most significant bit first on a single serial line. After exactly 26 shift steps the block stops by itself and reloads the held word, so the next press sends the same train again. A new word can be loaded through a parallel port with a one-cycle strobe, but only while no burst is running.

Every register runs on the one system clock. The shift rate is half the system clock rate. A toggle register sets that rate, and its rising edge is detected in the system clock domain and used as a clock enable. The toggle never drives a clock pin. The edge detection adds a lag of one cycle, so each shift lands one cycle after the gated shift-clock output goes high. The raw button first passes through a synchronizer and a debounce filter. Only a clean rising level of the filtered signal produces a start pulse, which the burst engine then latches.

Top module: `burst_serializer`

## Requirements
- R1: After reset, busy and shift_clk are 0, the held word is 26'h3108889, and ser_out shows its bit 25, which is 1.
- R2: During a burst ser_out presents the word from bit 25 down to bit 0. Each bit stays on the line for exactly two system clock cycles, starting in the cycle in which busy is first seen high.
- R3: A burst makes exactly 26 shift steps. busy stays high for exactly 52 cycles and then drops without any further input.
- R4: shift_clk is 0 in the first cycle of each bit and 1 in the second cycle, so it has a period of two cycles during a burst. It is 0 whenever busy is 0.
- R5: Each shift takes effect at the clock edge that follows a rising edge of shift_clk, one cycle after that rise.
- R6: A load strobe while busy is high has no effect: neither the bits still to be sent nor the word held for later bursts change.
- R7: A new button press while busy is high is ignored. A button that is held through the end of a burst does not start another one.
- R8: A button pulse shorter than the debounce length (4 cycles by default, after a 2-stage synchronizer) starts no burst.
- R9: When a burst ends, the shift register reloads the held word. ser_out then shows its bit 25 again, and the next press sends the same word.
- R10: When a load strobe and a start fall in the same idle cycle, the load is accepted and that burst sends the newly loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Unfiltered push-button level |
| load_strobe | input | 1 | One-cycle request to take load_word |
| load_word | input | 26 | Parallel word to hold and send |
| ser_out | output | 1 | Serial data, current most significant bit |
| shift_clk | output | 1 | Gated half-rate shift clock, low when idle |
| busy | output | 1 | High while a burst is running |

## Verification
The parallel load and the burst start can land in the same clock edge. The bench forces this by holding the button down while it strobes a different word on every idle cycle. The word expected in the burst is therefore the one on the port at the edge where busy rises. The bench then checks every bit of the train against that last word, which would expose a start that wins over the load or a stale held value. The bench also hits the pairing of a load with a running shift, and of a button press with a running burst, and judges each one at the serial output and in the next burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic level;
        logic level_q;
    } btn_state_t;

    localparam int unsigned DEF_WORD_W  = 26;
    localparam logic [25:0] DEF_PRESET  = 26'h3108889;
    localparam int unsigned DEF_SYNC    = 2;
    localparam int unsigned DEF_DEBOUNCE = 4;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/btn_filter.sv
module btn_filter
    import burst_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC,
    parameter int unsigned DEB_CYC     = DEF_DEBOUNCE
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic req
);
    localparam int unsigned DW = cnt_width(DEB_CYC + 1);
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   raw_s;
    logic [DW-1:0]          deb_cnt;
    btn_state_t             st;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= raw_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
            end
        end
    endgenerate

    assign raw_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            deb_cnt <= '0;
            st      <= '0;
        end else begin
            st.level_q <= st.level;
            if (raw_s == st.level) begin
                deb_cnt <= '0;
            end else if (deb_cnt == DEB_LAST) begin
                deb_cnt  <= '0;
                st.level <= raw_s;
            end else begin
                deb_cnt <= deb_cnt + 1'b1;
            end
        end
    end

    assign req = st.level & ~st.level_q;

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

endmodule

// File: rtl/rate_div.sv
module rate_div (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tog,
    output logic step
);
    logic tog_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog   <= 1'b0;
            tog_d <= 1'b0;
        end else begin
            tog   <= run ? ~tog : 1'b0;
            tog_d <= tog;
        end
    end

    assign step = run & tog & ~tog_d;

    a_r4_step_spacing: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);

endmodule

// File: rtl/shift_engine.sv
module shift_engine
    import burst_pkg::*;
#(
    parameter int unsigned       WORD_W = DEF_WORD_W,
    parameter logic [WORD_W-1:0] PRESET = WORD_W'(DEF_PRESET)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_word,
    output logic              busy,
    output logic              dout
);
    localparam int unsigned CW = cnt_width(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    phase_e            phase;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] shreg_q;
    logic [CW-1:0]     cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            hold_q  <= PRESET;
            shreg_q <= PRESET;
            cnt_q   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (load_en) begin
                        hold_q  <= load_word;
                        shreg_q <= load_word;
                    end
                    if (start) begin
                        phase <= PH_RUN;
                        cnt_q <= '0;
                    end
                end
                PH_RUN: begin
                    if (step) begin
                        if (cnt_q == LAST) begin
                            phase   <= PH_IDLE;
                            shreg_q <= hold_q;
                            cnt_q   <= '0;
                        end else begin
                            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase == PH_RUN);
    assign dout = shreg_q[WORD_W-1];

    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(hold_q));

    a_r5_shift_only_on_step: assert property (@(posedge clk) disable iff (rst)
        (busy && !step) |=> $stable(shreg_q));

    a_r3_ends_on_step: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(step));

    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= LAST));

endmodule

// File: rtl/burst_serializer.sv
module burst_serializer
    import burst_pkg::*;
#(
    parameter int unsigned       WORD_W      = DEF_WORD_W,
    parameter logic [WORD_W-1:0] PRESET      = WORD_W'(DEF_PRESET),
    parameter int unsigned       SYNC_STAGES = DEF_SYNC,
    parameter int unsigned       DEB_CYC     = DEF_DEBOUNCE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_raw,
    input  logic              load_strobe,
    input  logic [WORD_W-1:0] load_word,
    output logic              ser_out,
    output logic              shift_clk,
    output logic              busy
);
    logic start_req;
    logic step_en;
    logic tog;

    btn_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .DEB_CYC    (DEB_CYC)
    ) u_btn (
        .clk   (clk),
        .rst   (rst),
        .raw_in(btn_raw),
        .req   (start_req)
    );

    rate_div u_div (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .tog (tog),
        .step(step_en)
    );

    shift_engine #(
        .WORD_W(WORD_W),
        .PRESET(PRESET)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start_req),
        .step     (step_en),
        .load_en  (load_strobe),
        .load_word(load_word),
        .busy     (busy),
        .dout     (ser_out)
    );

    assign shift_clk = tog;

    a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !shift_clk);

    a_r5_step_after_rise: assert property (@(posedge clk) disable iff (rst)
        step_en |-> (shift_clk && !$past(shift_clk)));

endmodule

// File: tb/burst_serializer_tb.sv
module burst_serializer_tb_top;

    localparam int W = 26;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         btn = 1'b0;
    logic         ld  = 1'b0;
    logic [W-1:0] din = '0;
    logic         ser_out, shift_clk, busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    burst_serializer dut_i (
        .clk        (clk),
        .rst        (rst),
        .btn_raw    (btn),
        .load_strobe(ld),
        .load_word  (din),
        .ser_out    (ser_out),
        .shift_clk  (shift_clk),
        .busy       (busy)
    );

    localparam int NV = 6;
    localparam logic [W-1:0] VEC_WORD [NV] = '{
        26'h3108889, 26'h3FFFFFF, 26'h0000000,
        26'h2AAAAAA, 26'h2AAAAAA, 26'h1234567 };
    localparam bit VEC_LOAD [NV] = '{0, 1, 1, 1, 0, 1};
    localparam int VEC_MODE [NV] = '{0, 0, 0, 1, 0, 2};

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_one(input logic [W-1:0] w);
        @(negedge clk);
        ld  = 1'b1;
        din = w;
        @(negedge clk);
        ld  = 1'b0;
    endtask

    task automatic press_wait();
        bit seen = 1'b0;
        btn = 1'b1;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
        end
        chk("R2", {31'd0, seen}, 32'd1, "burst did not start");
    endtask

    // Called at the negedge where busy is first seen high.
    task automatic stream(input logic [W-1:0] exp, input int mode);
        for (int i = 0; i < W; i++) begin
            chk("R2", {31'd0, ser_out}, {31'd0, exp[W-1-i]}, $sformatf("bit %0d first cycle", i));
            chk("R4", {31'd0, shift_clk}, 32'd0, $sformatf("sclk low bit %0d", i));
            chk("R3", {31'd0, busy}, 32'd1, $sformatf("busy at bit %0d", i));
            if (mode == 1 && i == 5) begin ld = 1'b1; din = ~exp; end
            if (i == 2 && mode != 2) btn = 1'b0;
            if (mode == 2 && i == 3) btn = 1'b0;
            if (mode == 2 && i == 18) btn = 1'b1;
            @(negedge clk);
            ld = 1'b0;
            chk("R5", {31'd0, shift_clk}, 32'd1, $sformatf("sclk high bit %0d", i));
            chk("R2", {31'd0, ser_out}, {31'd0, exp[W-1-i]}, $sformatf("bit %0d second cycle", i));
            @(negedge clk);
        end
        chk("R3", {31'd0, busy}, 32'd0, "busy after 52 cycles");
        chk("R4", {31'd0, shift_clk}, 32'd0, "sclk idle after burst");
        chk("R9", {31'd0, ser_out}, {31'd0, exp[W-1]}, "reloaded msb");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", {31'd0, busy}, 32'd0, "busy after reset");
        chk("R1", {31'd0, shift_clk}, 32'd0, "sclk after reset");
        chk("R1", {31'd0, ser_out}, 32'd1, "ser_out after reset");

        for (int v = 0; v < NV; v++) begin
            if (VEC_LOAD[v]) load_one(VEC_WORD[v]);
            press_wait();
            stream(VEC_WORD[v], VEC_MODE[v]);
            if (VEC_MODE[v] == 1)
                chk("R6", {31'd0, ser_out}, {31'd0, VEC_WORD[v][W-1]}, "held word after ignored load");
            if (VEC_MODE[v] == 2) begin
                for (int k = 0; k < 20; k++) begin
                    chk("R7", {31'd0, busy}, 32'd0, "restart from held button");
                    @(negedge clk);
                end
                btn = 1'b0;
            end
            idle(15);
        end

        // R8: short spike must not start a burst
        btn = 1'b1;
        idle(2);
        btn = 1'b0;
        for (int k = 0; k < 20; k++) begin
            chk("R8", {31'd0, busy}, 32'd0, "spike started burst");
            @(negedge clk);
        end

        // R10: load strobe in the same cycle as the start
        begin
            logic [W-1:0] last_w;
            bit seen;
            last_w = '0;
            seen   = 1'b0;
            btn = 1'b1;
            for (int k = 0; k < 60 && !seen; k++) begin
                if (busy) seen = 1'b1;
                else begin
                    last_w = W'(k * 32'h00B3A5C1 + 32'h1C3);
                    ld  = 1'b1;
                    din = last_w;
                    @(negedge clk);
                end
            end
            ld = 1'b0;
            chk("R10", {31'd0, seen}, 32'd1, "start with load");
            stream(last_w, 0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule